// File: doc/BRIEF.md
# Scaled-Index Effective Address Generator

This block forms a linear memory address from up to four contributions: a segment base chosen by a selector, an optional base register, an optional index register multiplied by 1, 2, 4 or 8, and a signed 32-bit displacement. The two general register values come from a register file outside the block. The block presents the register numbers on read-index outputs, and the register file answers on value inputs within the same cycle. The six segment bases sit in a small table inside the block and are loaded through a write port.

A request is a single-cycle strobe that carries every operand field. One clock later the block presents the 64-bit address and a fault flag, and raises a valid pulse for one cycle. The block checks the operand combination before it trusts the sum. An index taken from the stack-pointer register, a scale with no index, a reference with neither a base nor a displacement, and a selector beyond the six segments all raise the fault flag. A faulting request returns address zero.

Top module: `ea_addr_gen`

## Requirements
- R1: The address is seg_base + base_reg + (index_reg << req_scale) + displacement, where the scale code 0, 1, 2 or 3 multiplies the index by 1, 2, 4 or 8.
- R2: The 32-bit displacement is sign-extended to 64 bits, and the sum wraps modulo 2^64.
- R3: A base with req_base_en low, an index with req_index_en low, or a displacement with req_disp_en low adds zero to the address.
- R4: A request with req_index_en high and req_index_idx equal to 4 (the stack pointer) sets out_err.
- R5: A request with req_index_en low and a nonzero req_scale sets out_err.
- R6: A request with both req_base_en and req_disp_en low sets out_err.
- R7: Selector codes 0 to 5 pick table entries 0 to 5. Selector codes 6 and 7 set out_err.
- R8: When out_err is set, out_addr is zero.
- R9: A write with seg_we high and seg_wsel from 0 to 5 loads that table entry. A request in the same cycle still sees the old value, and a request from the next cycle on sees the new value. Writes with seg_wsel 6 or 7 change no entry.
- R10: out_valid is high for exactly the cycle after each cycle in which req_valid is high. In every other cycle out_valid is low, and out_addr and out_err hold their values.
- R11: After reset, out_valid, out_err and out_addr are zero, and all six segment bases are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seg_we | input | 1 | Segment table write enable |
| seg_wsel | input | 3 | Segment table entry to write |
| seg_wdata | input | 64 | Segment base value to write |
| req_valid | input | 1 | Request strobe |
| req_seg | input | 3 | Segment selector |
| req_base_en | input | 1 | Base register present |
| req_base_idx | input | 4 | Base register number |
| req_index_en | input | 1 | Index register present |
| req_index_idx | input | 4 | Index register number |
| req_scale | input | 2 | Index shift amount (scale code) |
| req_disp_en | input | 1 | Displacement present |
| req_disp | input | 32 | Signed displacement |
| base_rd_idx | output | 4 | Register file read index for the base |
| base_rd_val | input | 64 | Register file value for the base |
| index_rd_idx | output | 4 | Register file read index for the index |
| index_rd_val | input | 64 | Register file value for the index |
| out_valid | output | 1 | One-cycle result strobe |
| out_addr | output | 64 | Linear address, zero on fault |
| out_err | output | 1 | Illegal operand combination |

## Verification
The hardest case to reach from the ports is a segment write and a request in the same clock. The request must use the old base, and the written value must show up on the following request. The bench raises the write enable and the request strobe together at one edge and then issues a second request. Ignored writes to selector codes 6 and 7 cannot be seen directly. The bench therefore reads all six bases back with displacement-only requests of zero, so that any stray update appears at out_addr.

// File: rtl/ea_pkg.sv
package ea_pkg;
  localparam int ADDR_W  = 64;
  localparam int DISP_W  = 32;
  localparam int RIDX_W  = 4;
  localparam int SEL_W   = 3;
  localparam int SCALE_W = 2;
  localparam int NUM_SEG = 6;
  localparam int SP_REG  = 4;

  typedef struct packed {
    logic sp_as_index;
    logic orphan_scale;
    logic empty_ref;
    logic bad_seg;
  } ea_fault_t;
endpackage

// File: rtl/seg_base_table.sv
module seg_base_table #(
  parameter int DW   = 64,
  parameter int NSEG = 6,
  parameter int SELW = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [SELW-1:0] wsel,
  input  logic [DW-1:0]   wdata,
  input  logic [SELW-1:0] rsel,
  output logic [DW-1:0]   rdata
);
  logic [DW-1:0] mem [NSEG];

  always_ff @(posedge clk) begin
    for (int i = 0; i < NSEG; i++) begin
      if (rst)
        mem[i] <= '0;
      else if (we && wsel == SELW'(i))
        mem[i] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NSEG; i++)
      if (rsel == SELW'(i)) rdata = mem[i];
  end

  generate
    for (genvar g = 0; g < NSEG; g++) begin : g_keep
      // R9
      entry_keep_chk: assert property (@(posedge clk) disable iff (rst)
        !(we && wsel == SELW'(g)) |=> $stable(mem[g]));
    end
  endgenerate
endmodule

// File: rtl/ea_check.sv
module ea_check
  import ea_pkg::*;
#(
  parameter int RIDXW = 4,
  parameter int SELW  = 3,
  parameter int SCW   = 2,
  parameter int NSEG  = 6,
  parameter int SPIDX = 4
) (
  input  logic [SELW-1:0]  seg,
  input  logic             base_en,
  input  logic             index_en,
  input  logic [RIDXW-1:0] index_idx,
  input  logic [SCW-1:0]   scale,
  input  logic             disp_en,
  output ea_fault_t        fault
);
  always_comb begin
    fault.sp_as_index  = index_en && (index_idx == RIDXW'(SPIDX));
    fault.orphan_scale = !index_en && (scale != '0);
    fault.empty_ref    = !base_en && !disp_en;
    fault.bad_seg      = (seg >= SELW'(NSEG));
  end
endmodule

// File: rtl/ea_adder.sv
module ea_adder #(
  parameter int AW  = 64,
  parameter int DW  = 32,
  parameter int SCW = 2
) (
  input  logic [AW-1:0]  seg_base,
  input  logic           base_en,
  input  logic [AW-1:0]  base_val,
  input  logic           index_en,
  input  logic [AW-1:0]  index_val,
  input  logic [SCW-1:0] scale,
  input  logic           disp_en,
  input  logic [DW-1:0]  disp,
  output logic [AW-1:0]  sum
);
  logic [AW-1:0] base_term, index_term, disp_term;

  always_comb begin
    base_term  = base_en  ? base_val : '0;
    index_term = index_en ? (index_val << scale) : '0;
    disp_term  = disp_en  ? {{(AW-DW){disp[DW-1]}}, disp} : '0;
    sum        = seg_base + base_term + index_term + disp_term;
  end
endmodule

// File: rtl/ea_addr_gen.sv
module ea_addr_gen
  import ea_pkg::*;
#(
  parameter int AW    = ADDR_W,
  parameter int DW    = DISP_W,
  parameter int RIDXW = RIDX_W,
  parameter int SELW  = SEL_W,
  parameter int SCW   = SCALE_W,
  parameter int NSEG  = NUM_SEG,
  parameter int SPIDX = SP_REG
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             seg_we,
  input  logic [SELW-1:0]  seg_wsel,
  input  logic [AW-1:0]    seg_wdata,
  input  logic             req_valid,
  input  logic [SELW-1:0]  req_seg,
  input  logic             req_base_en,
  input  logic [RIDXW-1:0] req_base_idx,
  input  logic             req_index_en,
  input  logic [RIDXW-1:0] req_index_idx,
  input  logic [SCW-1:0]   req_scale,
  input  logic             req_disp_en,
  input  logic [DW-1:0]    req_disp,
  output logic [RIDXW-1:0] base_rd_idx,
  input  logic [AW-1:0]    base_rd_val,
  output logic [RIDXW-1:0] index_rd_idx,
  input  logic [AW-1:0]    index_rd_val,
  output logic             out_valid,
  output logic [AW-1:0]    out_addr,
  output logic             out_err
);
  logic [AW-1:0] seg_base;
  logic [AW-1:0] raw_sum;
  ea_fault_t     fault;
  logic          any_fault;

  assign base_rd_idx  = req_base_idx;
  assign index_rd_idx = req_index_idx;

  seg_base_table #(.DW(AW), .NSEG(NSEG), .SELW(SELW)) u_segtab (
    .clk(clk), .rst(rst), .we(seg_we), .wsel(seg_wsel), .wdata(seg_wdata),
    .rsel(req_seg), .rdata(seg_base)
  );

  ea_check #(.RIDXW(RIDXW), .SELW(SELW), .SCW(SCW), .NSEG(NSEG), .SPIDX(SPIDX)) u_check (
    .seg(req_seg), .base_en(req_base_en), .index_en(req_index_en),
    .index_idx(req_index_idx), .scale(req_scale), .disp_en(req_disp_en),
    .fault(fault)
  );

  ea_adder #(.AW(AW), .DW(DW), .SCW(SCW)) u_add (
    .seg_base(seg_base), .base_en(req_base_en), .base_val(base_rd_val),
    .index_en(req_index_en), .index_val(index_rd_val), .scale(req_scale),
    .disp_en(req_disp_en), .disp(req_disp), .sum(raw_sum)
  );

  assign any_fault = |fault;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_err   <= 1'b0;
    end else begin
      out_valid <= req_valid;
      if (req_valid) begin
        out_err  <= any_fault;
        out_addr <= any_fault ? '0 : raw_sum;
      end
    end
  end

  // R10
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> out_valid);
  // R10
  valid_only_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !out_valid);
  // R10
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> ($stable(out_addr) && $stable(out_err)));
  // R4
  sp_index_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_index_en && req_index_idx == RIDXW'(SPIDX)) |=> out_err);
  // R6
  empty_ref_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_base_en && !req_disp_en) |=> out_err);
  // R8
  fault_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_err) |-> (out_addr == '0));
endmodule

// File: tb/ea_addr_gen_bench.sv
`timescale 1ns/1ps
module ea_addr_gen_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        seg_we = 1'b0;
  logic [2:0]  seg_wsel = '0;
  logic [63:0] seg_wdata = '0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_seg = '0;
  logic        req_base_en = 1'b0;
  logic [3:0]  req_base_idx = '0;
  logic        req_index_en = 1'b0;
  logic [3:0]  req_index_idx = '0;
  logic [1:0]  req_scale = '0;
  logic        req_disp_en = 1'b0;
  logic [31:0] req_disp = '0;
  logic [3:0]  base_rd_idx, index_rd_idx;
  logic [63:0] base_rd_val, index_rd_val;
  logic        out_valid, out_err;
  logic [63:0] out_addr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [63:0] segb [6];

  always #2.5 clk = ~clk;

  ea_addr_gen u_ea_addr_gen (
    .clk(clk), .rst(rst), .seg_we(seg_we), .seg_wsel(seg_wsel), .seg_wdata(seg_wdata),
    .req_valid(req_valid), .req_seg(req_seg), .req_base_en(req_base_en),
    .req_base_idx(req_base_idx), .req_index_en(req_index_en),
    .req_index_idx(req_index_idx), .req_scale(req_scale), .req_disp_en(req_disp_en),
    .req_disp(req_disp), .base_rd_idx(base_rd_idx), .base_rd_val(base_rd_val),
    .index_rd_idx(index_rd_idx), .index_rd_val(index_rd_val),
    .out_valid(out_valid), .out_addr(out_addr), .out_err(out_err)
  );

  function automatic logic [63:0] rf_val(input logic [3:0] i);
    return 64'h0000_0100_0000_0000 + 64'(i) * 64'h0000_0000_0001_0011;
  endfunction

  assign base_rd_val  = rf_val(base_rd_idx);
  assign index_rd_val = rf_val(index_rd_idx);

  // vector: seg, base_en, base_idx, index_en, index_idx, scale, disp_en, disp, expected err
  localparam int NV = 12;
  localparam logic [48:0] VEC [NV] = '{
    {3'd1, 1'b1, 4'd3,  1'b0, 4'd0,  2'd0, 1'b0, 32'h0000_0000, 1'b0},
    {3'd0, 1'b0, 4'd0,  1'b0, 4'd0,  2'd0, 1'b1, 32'h0000_1234, 1'b0},
    {3'd2, 1'b1, 4'd1,  1'b1, 4'd2,  2'd3, 1'b1, 32'h0000_0100, 1'b0},
    {3'd3, 1'b1, 4'd0,  1'b1, 4'd15, 2'd1, 1'b1, 32'hFFFF_FFF0, 1'b0},
    {3'd5, 1'b0, 4'd9,  1'b1, 4'd7,  2'd2, 1'b1, 32'h0000_0008, 1'b0},
    {3'd4, 1'b1, 4'd4,  1'b0, 4'd0,  2'd0, 1'b0, 32'h0000_0000, 1'b0},
    {3'd1, 1'b1, 4'd2,  1'b1, 4'd4,  2'd0, 1'b0, 32'h0000_0000, 1'b1},
    {3'd1, 1'b1, 4'd2,  1'b0, 4'd0,  2'd2, 1'b0, 32'h0000_0000, 1'b1},
    {3'd1, 1'b0, 4'd0,  1'b1, 4'd3,  2'd1, 1'b0, 32'h0000_0000, 1'b1},
    {3'd6, 1'b1, 4'd0,  1'b0, 4'd0,  2'd0, 1'b0, 32'h0000_0000, 1'b1},
    {3'd7, 1'b0, 4'd0,  1'b0, 4'd0,  2'd0, 1'b1, 32'h0000_0040, 1'b1},
    {3'd0, 1'b0, 4'd0,  1'b0, 4'd0,  2'd0, 1'b0, 32'h0000_0000, 1'b1}
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] model(input logic [48:0] v);
    logic [63:0] a;
    a = (v[48:46] < 3'd6) ? segb[v[48:46]] : 64'h0;
    if (v[45]) a = a + rf_val(v[44:41]);
    if (v[40]) a = a + (rf_val(v[39:36]) << v[35:34]);
    if (v[33]) a = a + {{32{v[32]}}, v[32:1]};
    return v[0] ? 64'h0 : a;
  endfunction

  task automatic issue(input logic [48:0] v);
    @(negedge clk);
    req_valid = 1'b1;
    {req_seg, req_base_en, req_base_idx, req_index_en, req_index_idx,
     req_scale, req_disp_en, req_disp} = v[48:1];
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic seg_write(input logic [2:0] s, input logic [63:0] d);
    @(negedge clk);
    seg_we = 1'b1; seg_wsel = s; seg_wdata = d;
    if (s < 3'd6) segb[s] = d;
    @(negedge clk);
    seg_we = 1'b0;
  endtask

  function automatic logic [48:0] disp_only(input logic [2:0] s, input logic [31:0] d);
    return {s, 1'b0, 4'd0, 1'b0, 4'd0, 2'd0, 1'b1, d, 1'b0};
  endfunction

  initial begin
    logic [63:0] held;
    for (int i = 0; i < 6; i++) segb[i] = 64'h0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state at the ports
    check(out_valid == 1'b0, "R11 valid", 64'(out_valid), 64'h0);
    check(out_err == 1'b0, "R11 err", 64'(out_err), 64'h0);
    check(out_addr == 64'h0, "R11 addr", out_addr, 64'h0);
    // R11 bases cleared: displacement-only read of segment 2
    issue(disp_only(3'd2, 32'h5));
    check(out_addr == 64'h5, "R11 seg base zero", out_addr, 64'h5);

    for (int i = 0; i < 6; i++) seg_write(3'(i), 64'(i + 1) << 40);

    // R1 R2 R3 R4 R5 R6 R7 R8 through the vector table
    for (int k = 0; k < NV; k++) begin
      issue(VEC[k]);
      check(out_valid == 1'b1, "R10 valid pulse", 64'(out_valid), 64'h1);
      check(out_err == VEC[k][0], "R4/R5/R6/R7 err", 64'(out_err), 64'(VEC[k][0]));
      check(out_addr == model(VEC[k]), "R1/R2/R3/R8 addr", out_addr, model(VEC[k]));
    end

    // R10 out_valid drops and results hold when idle
    held = out_addr;
    @(negedge clk);
    check(out_valid == 1'b0, "R10 valid low", 64'(out_valid), 64'h0);
    check(out_addr == held, "R10 addr hold", out_addr, held);
    check(out_err == 1'b1, "R10 err hold", 64'(out_err), 64'h1);

    // R2 wrap past 2^64
    seg_write(3'd0, 64'hFFFF_FFFF_FFFF_FFF0);
    issue(disp_only(3'd0, 32'h20));
    check(out_addr == 64'h10, "R2 wrap", out_addr, 64'h10);

    // R9 writes to selector codes 6 and 7 are dropped
    seg_write(3'd6, 64'hDEAD_BEEF_0000_0001);
    seg_write(3'd7, 64'hDEAD_BEEF_0000_0002);
    for (int s = 0; s < 6; s++) begin
      issue(disp_only(3'(s), 32'h0));
      check(out_addr == segb[s], "R9 ignored high select", out_addr, segb[s]);
    end

    // R9 same-edge write and request: old base first, new base next
    @(negedge clk);
    seg_we = 1'b1; seg_wsel = 3'd3; seg_wdata = 64'h0000_0ABC_0000_0000;
    req_valid = 1'b1;
    {req_seg, req_base_en, req_base_idx, req_index_en, req_index_idx,
     req_scale, req_disp_en, req_disp} = disp_only(3'd3, 32'h7)[48:1];
    @(negedge clk);
    seg_we = 1'b0; req_valid = 1'b0;
    check(out_addr == segb[3] + 64'h7, "R9 same cycle old", out_addr, segb[3] + 64'h7);
    segb[3] = 64'h0000_0ABC_0000_0000;
    issue(disp_only(3'd3, 32'h7));
    check(out_addr == segb[3] + 64'h7, "R9 next cycle new", out_addr, segb[3] + 64'h7);

    // R10 back-to-back requests keep out_valid high
    @(negedge clk);
    req_valid = 1'b1;
    {req_seg, req_base_en, req_base_idx, req_index_en, req_index_idx,
     req_scale, req_disp_en, req_disp} = disp_only(3'd1, 32'h1)[48:1];
    @(negedge clk);
    check(out_valid && out_addr == segb[1] + 64'h1, "R10 first", out_addr, segb[1] + 64'h1);
    req_disp = 32'h2;
    @(negedge clk);
    req_valid = 1'b0;
    check(out_valid && out_addr == segb[1] + 64'h2, "R10 second", out_addr, segb[1] + 64'h2);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%h expected=%h", 64'h0, 64'h1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule